// File: doc/BRIEF.md
# Bit-Oriented Message Link Controller

This block sends and receives short code-word messages on the facility data link of a T1 framer that runs in extended-superframe mode. The data link is a serial stream. One data-link bit moves on each cycle in which the bit strobe is high. The surrounding framer supplies that strobe at about 4 kbit/s and handles frame and multiframe alignment.

On the send side, software writes a 6-bit code. While sending is enabled, the block repeats a 16-bit pattern: a flag of eight ones, then the code byte in the form `0cccccc0`. On the receive side, the block hunts for the flag and takes the following byte. It votes over the most recent byte positions, and it adopts a message only after that message is seen consistently. A new adopted message raises one interrupt. A second interrupt fires when the adopted message equals a software-programmed match byte. Other traffic on the link contains no eight-ones flag, so it leaves the held message untouched.

Register map (`reg_addr`): 0 control (bit0 send enable, bit1 new-message interrupt enable, bit2 match interrupt enable); 1 transmit code (written as `wdata[6:1]`, read back as `0cccccc0`); 2 match byte; 3 received message (read only); 4 status (bit0 new-message pending, bit1 match pending; writing 1 to a bit clears it). Any other address reads as zero.

Top module: `bom_link_ctrl`

## Requirements
- R1: After reset, `tx_bit` is 1, both interrupt outputs are low, and every register reads as zero.
- R2: When control bit0 is set and `esf_mode` is high, `tx_bit` carries, most significant first and one bit per strobe, the pattern of eight ones followed by the byte `{0, code[5:0], 0}`. The pattern repeats with no gap.
- R3: While `esf_mode` is low, `tx_bit` stays 1 and no received byte position is counted or adopted.
- R4: With control bit0 clear, `tx_bit` stays 1.
- R5: A write to the transmit code register during a pattern does not change the pattern being sent. The new code appears from the next 16-bit pattern onward.
- R6: The receiver treats the 8 bits that follow eight consecutive ones as one byte position and then hunts again. A byte whose bit7 or bit0 is 1 counts as a non-matching position.
- R7: A valid byte is adopted into the received message register (address 3) only when it equals at least 8 of the last 10 byte positions, counting the current one, and it differs from the held message.
- R8: Adopting a message sets status bit0. `irq_new` equals status bit0 AND control bit1. Writing 1 to status bit0 clears it.
- R9: When an adopted message equals the match byte (address 2), status bit1 is set. `irq_match` equals status bit1 AND control bit2.
- R10: Traffic that never contains eight consecutive ones leaves the held message and the status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| esf_mode | input | 1 | High when the framer runs in extended-superframe mode |
| dl_strobe | input | 1 | One pulse per data-link bit |
| rx_bit | input | 1 | Received data-link bit, valid with the strobe |
| tx_bit | output | 1 | Transmitted data-link bit |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| irq_new | output | 1 | New-message interrupt |
| irq_match | output | 1 | Match interrupt |

## Verification
The bench builds the block with its default parameters: an 8-bit flag, a 10-position history and a threshold of 8. At these values a full message needs only 16 strobes, so a few dozen messages are enough to fill the history and to show where acceptance happens. The bench interleaves corrupt byte positions so that adoption is shown at exactly the eighth match and not one position earlier. It also places a code write in the middle of a pattern to expose the boundary rule.

// File: rtl/bom_pkg.sv
package bom_pkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic                ok;
    logic [BYTE_W-1:0]   code;
  } bom_entry_t;

  // Wrap a 6-bit code into its on-line byte form 0cccccc0
  function automatic logic [BYTE_W-1:0] bom_byte(input logic [5:0] code);
    return {1'b0, code, 1'b0};
  endfunction

  // A byte position is usable only with zero framing bits at both ends
  function automatic logic bom_pos_ok(input logic [BYTE_W-1:0] b);
    return (b[BYTE_W-1] == 1'b0) && (b[0] == 1'b0);
  endfunction
endpackage

// File: rtl/bom_tx.sv
module bom_tx #(
  parameter int FLAG_LEN = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active,
  input  logic       stb,
  input  logic [5:0] code_reg,
  output logic       tx_bit
);
  localparam int PAT_W = FLAG_LEN + bom_pkg::BYTE_W;
  localparam int CW    = $clog2(PAT_W);

  logic [CW-1:0] pos;
  logic [5:0]    cur_code;
  logic [bom_pkg::BYTE_W-1:0] cur_byte;

  assign cur_byte = bom_pkg::bom_byte(cur_code);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos      <= '0;
      cur_code <= '0;
    end else if (!active) begin
      pos      <= '0;
      cur_code <= code_reg;
    end else if (stb) begin
      if (pos == CW'(PAT_W - 1)) begin
        pos      <= '0;
        cur_code <= code_reg;
      end else begin
        pos <= pos + 1'b1;
      end
    end
  end

  always_comb begin
    if (!active || (int'(pos) < FLAG_LEN)) tx_bit = 1'b1;
    else tx_bit = cur_byte[PAT_W - 1 - int'(pos)];
  end
endmodule

// File: rtl/bom_rx_framer.sv
module bom_rx_framer #(
  parameter int FLAG_LEN = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       stb,
  input  logic       din,
  output logic       byte_stb,
  output logic [7:0] byte_q
);
  localparam int OW = $clog2(FLAG_LEN + 1);

  logic [OW-1:0] ones;
  logic          capt;
  logic [2:0]    bcnt;
  logic [7:0]    sh;
  logic [7:0]    sh_nxt;

  assign sh_nxt = {sh[6:0], din};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ones <= '0; capt <= 1'b0; bcnt <= '0; sh <= '0;
      byte_stb <= 1'b0; byte_q <= '0;
    end else begin
      byte_stb <= 1'b0;
      if (!en) begin
        ones <= '0; capt <= 1'b0; bcnt <= '0;
      end else if (stb) begin
        if (capt) begin
          sh <= sh_nxt;
          if (bcnt == 3'd7) begin
            byte_q   <= sh_nxt;
            byte_stb <= 1'b1;
            capt     <= 1'b0;
            ones     <= '0;
            bcnt     <= '0;
          end else begin
            bcnt <= bcnt + 1'b1;
          end
        end else if (ones == OW'(FLAG_LEN)) begin
          capt <= 1'b1;
          sh   <= {7'b0, din};
          bcnt <= 3'd1;
        end else if (din) begin
          ones <= ones + 1'b1;
        end else begin
          ones <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/bom_vote.sv
module bom_vote #(
  parameter int DEPTH = 10,
  parameter int MIN   = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byte_stb,
  input  logic [7:0] byte_in,
  output logic [7:0] held,
  output logic       accept
);
  import bom_pkg::*;
  localparam int NW = $clog2(DEPTH + 1);

  bom_entry_t    hist [DEPTH];
  bom_entry_t    cand;
  logic [NW-1:0] agree;
  logic          has_msg;

  assign cand.ok   = bom_pos_ok(byte_in);
  assign cand.code = byte_in;

  always_comb begin
    agree = cand.ok ? NW'(1) : '0;
    for (int i = 0; i < DEPTH - 1; i++)
      if (cand.ok && hist[i].ok && hist[i].code == byte_in) agree = agree + 1'b1;
  end

  assign accept = byte_stb && cand.ok && (int'(agree) >= MIN) &&
                  (!has_msg || byte_in != held);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) hist[i] <= '0;
      held <= '0; has_msg <= 1'b0;
    end else begin
      if (byte_stb) begin
        hist[0] <= cand;
        for (int i = 1; i < DEPTH; i++) hist[i] <= hist[i-1];
      end
      if (accept) begin
        held <= byte_in; has_msg <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/bom_link_ctrl.sv
module bom_link_ctrl #(
  parameter int FLAG_LEN = 8,
  parameter int DEPTH    = 10,
  parameter int MIN      = 8,
  parameter int ADDR_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              esf_mode,
  input  logic              dl_strobe,
  input  logic              rx_bit,
  output logic              tx_bit,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              irq_new,
  output logic              irq_match
);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_TXC   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_MATCH = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_RXM   = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(4);

  logic [2:0] ctrl;
  logic [5:0] tx_code;
  logic [7:0] match_reg;
  logic       new_pend, match_pend;

  logic       byte_stb;
  logic [7:0] byte_q;
  logic [7:0] rx_msg;
  logic       new_evt, match_evt;

  bom_tx #(.FLAG_LEN(FLAG_LEN)) u_tx (
    .clk(clk), .rst_n(rst_n), .active(ctrl[0] & esf_mode), .stb(dl_strobe),
    .code_reg(tx_code), .tx_bit(tx_bit));

  bom_rx_framer #(.FLAG_LEN(FLAG_LEN)) u_rx (
    .clk(clk), .rst_n(rst_n), .en(esf_mode), .stb(dl_strobe), .din(rx_bit),
    .byte_stb(byte_stb), .byte_q(byte_q));

  bom_vote #(.DEPTH(DEPTH), .MIN(MIN)) u_vote (
    .clk(clk), .rst_n(rst_n), .byte_stb(byte_stb & esf_mode), .byte_in(byte_q),
    .held(rx_msg), .accept(new_evt));

  assign match_evt = new_evt && (byte_q == match_reg);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0; tx_code <= '0; match_reg <= '0;
      new_pend <= 1'b0; match_pend <= 1'b0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          A_CTRL:  ctrl      <= reg_wdata[2:0];
          A_TXC:   tx_code   <= reg_wdata[6:1];
          A_MATCH: match_reg <= reg_wdata;
          default: ;
        endcase
      end
      if (new_evt) new_pend <= 1'b1;
      else if (reg_wr && reg_addr == A_STAT && reg_wdata[0]) new_pend <= 1'b0;
      if (match_evt) match_pend <= 1'b1;
      else if (reg_wr && reg_addr == A_STAT && reg_wdata[1]) match_pend <= 1'b0;
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {5'b0, ctrl};
      A_TXC:   reg_rdata = bom_pkg::bom_byte(tx_code);
      A_MATCH: reg_rdata = match_reg;
      A_RXM:   reg_rdata = rx_msg;
      A_STAT:  reg_rdata = {6'b0, match_pend, new_pend};
      default: reg_rdata = '0;
    endcase
  end

  assign irq_new   = new_pend & ctrl[1];
  assign irq_match = match_pend & ctrl[2];
endmodule

// File: rtl/bom_link_chk.sv
module bom_link_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       new_evt,
  input logic       match_evt,
  input logic [7:0] rx_msg,
  input logic       new_pend,
  input logic       match_pend
);
  AST_MATCH_NEEDS_NEW: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |-> new_evt); // R9
  AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !new_evt |=> $stable(rx_msg)); // R7
  AST_HELD_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    new_evt |=> (rx_msg[7] == 1'b0 && rx_msg[0] == 1'b0)); // R6
  AST_NEW_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    new_evt |=> new_pend); // R8
  AST_MATCH_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> match_pend); // R9
endmodule

bind bom_link_ctrl bom_link_chk u_chk (
  .clk(clk), .rst_n(rst_n), .new_evt(new_evt), .match_evt(match_evt),
  .rx_msg(rx_msg), .new_pend(new_pend), .match_pend(match_pend));

// File: tb/sim_bom_link_ctrl.sv
module sim_bom_link_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, esf_mode = 1'b0, dl_strobe = 1'b0, rx_bit = 1'b1;
  logic reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic tx_bit, irq_new, irq_match;
  logic [7:0] reg_rdata;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bom_link_ctrl u0 (.clk(clk), .rst_n(rst_n), .esf_mode(esf_mode), .dl_strobe(dl_strobe),
    .rx_bit(rx_bit), .tx_bit(tx_bit), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_new(irq_new), .irq_match(irq_match));

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  // one data-link bit: strobe for one cycle, then two idle cycles
  task automatic step(input logic b, output logic sent);
    @(negedge clk); sent = tx_bit; rx_bit = b; dl_strobe = 1'b1;
    @(negedge clk); dl_strobe = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) step(v[i], s);
  endtask

  task automatic send_msg(input logic [7:0] v);
    send_byte(8'hFF); send_byte(v);
  endtask

  function automatic logic [15:0] pattern(input logic [5:0] c);
    return {8'hFF, 1'b0, c, 1'b0};
  endfunction

  task automatic collect(input int n, output logic [31:0] bits);
    logic s;
    bits = '0;
    for (int i = 0; i < n; i++) begin step(1'b1, s); bits = {bits[30:0], s}; end
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R1 tx_bit", tx_bit, 1); chk("R1 irq_new", irq_new, 0); chk("R1 irq_match", irq_match, 0);
    for (int a = 0; a < 5; a++) begin rd(3'(a), d); chk("R1 reg readback", d, 0); end
  endtask

  task automatic t_tx_pattern;
    logic [31:0] got;
    logic [7:0] d;
    esf_mode = 1'b1;
    wr(3'd1, 8'h58);  // code 6'h2C
    rd(3'd1, d); chk("R2 code readback", d, 8'h58);
    wr(3'd0, 8'h01);
    collect(32, got);
    chk("R2 tx pattern x2", got, {pattern(6'h2C), pattern(6'h2C)});
  endtask

  task automatic t_tx_boundary;
    logic [31:0] a, b;
    collect(5, a);
    wr(3'd1, 8'h26);  // code 6'h13, written mid-pattern
    collect(11, b);
    chk("R5 old pattern finishes", {a[4:0], b[10:0]}, pattern(6'h2C));
    collect(16, a);
    chk("R5 new pattern at boundary", a[15:0], pattern(6'h13));
  endtask

  task automatic t_tx_off;
    logic [31:0] got;
    wr(3'd0, 8'h00);
    collect(16, got); chk("R4 send disabled gives ones", got[15:0], 16'hFFFF);
    wr(3'd0, 8'h01); esf_mode = 1'b0;
    collect(16, got); chk("R3 non-ESF gives ones", got[15:0], 16'hFFFF);
    esf_mode = 1'b1;
  endtask

  task automatic t_rx_accept;
    logic [7:0] d;
    wr(3'd2, 8'h5A); wr(3'd0, 8'h07);
    for (int i = 0; i < 7; i++) send_msg(8'h5A);
    rd(3'd3, d); chk("R7 not adopted after 7", d, 0);
    chk("R8 no irq before adoption", irq_new, 0);
    send_msg(8'h5A);
    rd(3'd3, d); chk("R7 adopted at 8", d, 8'h5A);
    chk("R8 irq_new", irq_new, 1); chk("R9 irq_match", irq_match, 1);
    wr(3'd4, 8'h03);
    chk("R8 cleared", irq_new, 0); chk("R9 cleared", irq_match, 0);
    send_msg(8'h5A); send_msg(8'h5A);
    chk("R7 repeat of held is not new", irq_new, 0);
  endtask

  task automatic t_rx_vote;
    logic [7:0] d;
    logic [7:0] seq [10] = '{8'h3C, 8'h3C, 8'h3D, 8'h3C, 8'h3C, 8'h3C, 8'hBC, 8'h3C, 8'h3C, 8'h3C};
    for (int i = 0; i < 9; i++) send_msg(seq[i]);
    rd(3'd3, d); chk("R6 bad framing bits not counted", d, 8'h5A);
    send_msg(seq[9]);
    rd(3'd3, d); chk("R7 adopted at 8 of 10", d, 8'h3C);
    chk("R8 irq_new", irq_new, 1); chk("R9 no match", irq_match, 0);
    wr(3'd4, 8'h01);
  endtask

  task automatic t_burst;
    logic [7:0] d;
    for (int i = 0; i < 12; i++) send_byte(8'h7E);
    rd(3'd3, d); chk("R10 held after burst", d, 8'h3C);
    rd(3'd4, d); chk("R10 status after burst", d, 0);
  endtask

  task automatic t_non_esf;
    logic [7:0] d;
    esf_mode = 1'b0;
    for (int i = 0; i < 10; i++) send_msg(8'h42);
    rd(3'd3, d); chk("R3 not adopted outside ESF", d, 8'h3C);
    esf_mode = 1'b1;
  endtask

  task automatic t_mask;
    logic [7:0] d;
    wr(3'd0, 8'h05);
    for (int i = 0; i < 10; i++) send_msg(8'h42);
    rd(3'd3, d); chk("R7 adopted", d, 8'h42);
    chk("R8 masked irq", irq_new, 0);
    rd(3'd4, d); chk("R8 status set while masked", d, 8'h01);
    wr(3'd0, 8'h07); chk("R8 irq after unmask", irq_new, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset(); t_tx_pattern(); t_tx_boundary(); t_tx_off();
    t_rx_accept(); t_rx_vote(); t_burst(); t_non_esf(); t_mask();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule